// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block lets a numeric coprocessor follow the instruction stream of the host CPU it sits beside. It never fetches code itself. It watches the shared data bus during host code-fetch cycles and copies each fetched byte into a local mirror of the host's prefetch queue. It then follows the host's two queue-status pins to see when the host removes a byte from its queue or discards the whole queue. It removes the same byte from the mirror, or clears the mirror.

The host can have an 8-bit or a 16-bit data bus. The block samples a status line while reset is held and keeps that choice until the next reset. A 16-bit host gets a six-byte mirror and a 16-bit code fetch delivers up to two bytes. An 8-bit host gets a four-byte mirror and one byte per fetch.

When the host takes the first byte of an instruction and that byte belongs to the escape class, the block waits for the next byte, which is the addressing-mode byte. Once that byte has also been taken, the block raises a one-cycle dispatch strobe that carries both bytes to the execution side. A fetch that would overfill the mirror is dropped and sets a sticky error flag.

Top module: `cq_shadow_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge the block empties the mirror, clears any pending escape opcode and drives `esc_valid` and `ovf_err` low.
- R2: `host_8bit` is sampled only at clock edges where `rst_n` is low. A value of 1 selects an 8-bit host with a depth of 4. A value of 0 selects a 16-bit host with a depth of 6. Changes to `host_8bit` after reset have no effect.
- R3: A code fetch whose bytes do not fit in the active depth is dropped whole. The room is counted after any take made in the same cycle. The fetch sets `ovf_err`, which stays high until reset, and entries already held are not overwritten.
- R4: For a 16-bit host, an even fetch (`fetch_odd`=0) pushes `data_bus[7:0]` and then `data_bus[15:8]`. An odd fetch pushes only `data_bus[15:8]`. For an 8-bit host, every fetch pushes only `data_bus[7:0]` and `fetch_odd` is ignored.
- R5: Bytes leave the mirror in the order in which they were fetched. A take and a fetch in the same cycle are both applied.
- R6: `qstat` is decoded as follows: 00 means no queue operation, 01 means the first byte of an instruction is taken, 11 means a following byte is taken, and 10 means the queue is flushed.
- R7: A flush code clears every entry and any pending escape opcode in that cycle. A code fetch in the same cycle is discarded.
- R8: A first-byte take whose top five bits are 11011 makes that byte pending. The next following-byte take then raises `esc_valid` for exactly one cycle, in the cycle after that take, with `esc_opcode` set to the pending byte and `esc_modrm` set to the byte just taken.
- R9: A following-byte take with no pending escape gives no strobe. A new first-byte take replaces any pending escape, or clears it when the new byte is not escape-class.
- R10: A take code when the mirror is empty removes nothing and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_8bit | input | 1 | Host bus-width status, sampled during reset (1 = 8-bit host) |
| code_fetch | input | 1 | High for one cycle when `data_bus` holds host code-fetch data |
| fetch_odd | input | 1 | Bit 0 of the host fetch address |
| data_bus | input | 16 | Shared host data bus |
| qstat | input | 2 | Host queue-status code |
| esc_valid | output | 1 | One-cycle dispatch strobe for an escape instruction |
| esc_opcode | output | 8 | Escape opcode byte, valid with the strobe |
| esc_modrm | output | 8 | Addressing-mode byte, valid with the strobe |
| ovf_err | output | 1 | Sticky mirror-overflow flag |

## Verification
A take and a fetch in the same cycle are driven together. A design that counted room before the take, or pushed before it popped, would report a false overflow or give the wrong strobe bytes. A flush is driven while an escape byte is pending, and again together with a code fetch. A design that kept the pending opcode, or let the fetch through, would strobe on stale or discarded bytes.

The queue is filled to its exact depth and then sent one more fetch. A design that overwrote an entry, or whose depth was one off, would drain a corrupted byte order or flag the error at the wrong fetch. The host-width input is flipped after an 8-bit reset, odd and even fetches are mixed, and a second escape opcode is taken while one is pending. A design that re-sampled the width, took the wrong byte lane or kept the older opcode would strobe the wrong bytes.

// File: rtl/cqs_pkg.sv
// Package: shared encodings for the coprocessor queue tracker.
// Assumes the host queue-status code is presented on two pins each cycle.
package cqs_pkg;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    localparam logic [4:0] ESC_PREFIX = 5'b11011;

    // Escape-class test on an opcode byte
    function automatic logic is_escape(input logic [7:0] b);
        return b[7:3] == ESC_PREFIX;
    endfunction

endpackage

// File: rtl/cqs_mirror_fifo.sv
// Mirror queue: a shift-style byte queue whose usable depth depends on the host type.
// Assumes at most two pushes and one pop per cycle. A push that does not fit is
// refused whole and reported on `overflow`. A flush wins over both push and pop.
module cqs_mirror_fifo #(
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4,
    parameter int W            = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wide,
    input  logic         flush,
    input  logic         pop_req,
    input  logic [1:0]   push_n,
    input  logic [W-1:0] push_b0,
    input  logic [W-1:0] push_b1,
    output logic [W-1:0] head,
    output logic         pop_ok,
    output logic         overflow
);
    localparam int DMAX = (DEPTH_WIDE > DEPTH_NARROW) ? DEPTH_WIDE : DEPTH_NARROW;
    localparam int CW   = $clog2(DMAX + 1);
    localparam logic [CW:0] D_WIDE   = (CW+1)'(DEPTH_WIDE);
    localparam logic [CW:0] D_NARROW = (CW+1)'(DEPTH_NARROW);

    logic [CW-1:0] count;
    logic [CW-1:0] cnt_after;
    logic [CW-1:0] wr1;
    logic [CW:0]   depth_act;
    logic [CW:0]   need;
    logic          do_push;
    logic [W-1:0]  mem [DMAX];

    // Room check against the depth for the sampled host type
    always_comb begin
        depth_act = wide ? D_WIDE : D_NARROW;
        pop_ok    = pop_req && (count != '0) && !flush;
        cnt_after = count - CW'(pop_ok);
        wr1       = CW'(cnt_after + CW'(1));
        need      = {1'b0, cnt_after} + (CW+1)'(push_n);
        do_push   = !flush && (push_n != 2'd0) && (need <= depth_act);
        overflow  = !flush && (push_n != 2'd0) && (need > depth_act);
    end

    assign head = mem[0];

    // One register per entry: shift on pop, then write the pushed bytes at the tail
    for (genvar i = 0; i < DMAX; i++) begin : g_ent
        logic [W-1:0] q;
        logic [W-1:0] shifted;
        logic [W-1:0] nxt;
        if (i == DMAX - 1) begin : g_last
            assign shifted = pop_ok ? '0 : q;
        end else begin : g_mid
            assign shifted = pop_ok ? mem[i+1] : q;
        end
        // Entry next-value selection
        always_comb begin
            nxt = shifted;
            if (do_push && cnt_after == CW'(i))
                nxt = push_b0;
            else if (do_push && push_n == 2'd2 && wr1 == CW'(i))
                nxt = push_b1;
        end
        // Entry storage, cleared by reset or flush
        always_ff @(posedge clk) begin
            if (!rst_n || flush) q <= '0;
            else                 q <= nxt;
        end
        assign mem[i] = q;
    end

    // Fill-level counter
    always_ff @(posedge clk) begin
        if (!rst_n || flush) count <= '0;
        else if (do_push)    count <= cnt_after + CW'(push_n);
        else                 count <= cnt_after;
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, count} <= depth_act);
    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
    p_overflow_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !pop_req) |=> $stable(count));

endmodule

// File: rtl/cqs_esc_assembler.sv
// Escape assembler: watches bytes leaving the mirror, holds an escape-class first
// byte and strobes it together with the following byte once that byte is taken.
// Assumes `take_ok` is qualified (the queue was not empty, and there was no flush).
module cqs_esc_assembler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       take_ok,
    input  logic       take_first,
    input  logic [7:0] take_byte,
    output logic       esc_valid,
    output logic [7:0] esc_opcode,
    output logic [7:0] esc_modrm
);
    import cqs_pkg::*;

    logic       pending;
    logic [7:0] held_op;

    // Pending-opcode tracking and one-cycle dispatch strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            held_op    <= '0;
            esc_valid  <= 1'b0;
            esc_opcode <= '0;
            esc_modrm  <= '0;
        end else begin
            esc_valid <= 1'b0;
            if (flush) begin
                pending <= 1'b0;
            end else if (take_ok && take_first) begin
                pending <= is_escape(take_byte);
                held_op <= take_byte;
            end else if (take_ok && pending) begin
                esc_valid  <= 1'b1;
                esc_opcode <= held_op;
                esc_modrm  <= take_byte;
                pending    <= 1'b0;
            end
        end
    end

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |=> !esc_valid);
    p_strobe_is_escape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> esc_opcode[7:3] == ESC_PREFIX);

endmodule

// File: rtl/cq_shadow_tracker.sv
// Top: coprocessor instruction queue tracker. Latches the host bus width during
// reset, turns host code fetches into pushes, decodes the queue-status pins into
// takes and flushes, and reports the assembled escape instruction.
// Assumes bus status is decoded externally into a one-cycle `code_fetch`.
module cq_shadow_tracker #(
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_8bit,
    input  logic        code_fetch,
    input  logic        fetch_odd,
    input  logic [15:0] data_bus,
    input  logic [1:0]  qstat,
    output logic        esc_valid,
    output logic [7:0]  esc_opcode,
    output logic [7:0]  esc_modrm,
    output logic        ovf_err
);
    import cqs_pkg::*;

    logic       wide_q;
    logic       flush;
    logic       take_req;
    logic       take_first;
    logic [1:0] push_n;
    logic [7:0] push_b0;
    logic [7:0] push_b1;
    logic [7:0] head;
    logic       pop_ok;
    logic       overflow;

    // Host width is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) wide_q <= ~host_8bit;
    end

    // Queue-status decode
    always_comb begin
        flush      = qstat == QS_FLUSH;
        take_first = qstat == QS_FIRST;
        take_req   = (qstat == QS_FIRST) || (qstat == QS_NEXT);
    end

    // Byte-lane selection for a code fetch
    always_comb begin
        push_n  = 2'd0;
        push_b0 = data_bus[7:0];
        push_b1 = data_bus[15:8];
        if (code_fetch) begin
            if (!wide_q) begin
                push_n = 2'd1;
            end else if (fetch_odd) begin
                push_n  = 2'd1;
                push_b0 = data_bus[15:8];
            end else begin
                push_n = 2'd2;
            end
        end
    end

    cqs_mirror_fifo #(
        .DEPTH_WIDE   (DEPTH_WIDE),
        .DEPTH_NARROW (DEPTH_NARROW),
        .W            (8)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_q),
        .flush    (flush),
        .pop_req  (take_req),
        .push_n   (push_n),
        .push_b0  (push_b0),
        .push_b1  (push_b1),
        .head     (head),
        .pop_ok   (pop_ok),
        .overflow (overflow)
    );

    cqs_esc_assembler asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .take_ok    (pop_ok),
        .take_first (take_first),
        .take_byte  (head),
        .esc_valid  (esc_valid),
        .esc_opcode (esc_opcode),
        .esc_modrm  (esc_modrm)
    );

    // Sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_err <= 1'b0;
        else if (overflow) ovf_err <= 1'b1;
    end

    p_width_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(wide_q));
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    p_strobe_after_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> $past(qstat) == 2'b11);

endmodule

// File: tb/cq_shadow_tracker_tb_top.sv
// Bench for the queue tracker. A per-cycle vector table is walked first, then
// directed tests cover reset, overflow and the 8-bit host.
module cq_shadow_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_8bit;
    logic        code_fetch;
    logic        fetch_odd;
    logic [15:0] data_bus;
    logic [1:0]  qstat;
    logic        esc_valid;
    logic [7:0]  esc_opcode;
    logic [7:0]  esc_modrm;
    logic        ovf_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cq_shadow_tracker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_8bit  (host_8bit),
        .code_fetch (code_fetch),
        .fetch_odd  (fetch_odd),
        .data_bus   (data_bus),
        .qstat      (qstat),
        .esc_valid  (esc_valid),
        .esc_opcode (esc_opcode),
        .esc_modrm  (esc_modrm),
        .ovf_err    (ovf_err)
    );

    // Row layout: fetch, odd, data[15:0], qstat[1:0], exp_valid, exp_op, exp_modrm
    localparam int NV = 27;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h06D9, 2'b00, 1'b0, 8'h00, 8'h00}, // 0  R4 push D9,06
        {1'b1, 1'b0, 16'h1122, 2'b00, 1'b0, 8'h00, 8'h00}, // 1  push 22,11
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 2  R6 take D9 (escape)
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 8'hD9, 8'h06}, // 3  R8 strobe D9/06
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 4  take 22
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 8'h00, 8'h00}, // 5  R9 take 11, none pending
        {1'b1, 1'b1, 16'hDCAB, 2'b00, 1'b0, 8'h00, 8'h00}, // 6  R4 odd: push DC only
        {1'b1, 1'b0, 16'h3377, 2'b01, 1'b0, 8'h00, 8'h00}, // 7  R5 take DC + push 77,33
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 8'hDC, 8'h77}, // 8  strobe DC/77
        {1'b0, 1'b0, 16'h0000, 2'b00, 1'b0, 8'h00, 8'h00}, // 9  R8 single-cycle
        {1'b1, 1'b0, 16'hDDDF, 2'b01, 1'b0, 8'h00, 8'h00}, // 10 take 33, push DF,DD
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 11 take DF
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 12 R9 DD replaces DF
        {1'b1, 1'b0, 16'h5544, 2'b00, 1'b0, 8'h00, 8'h00}, // 13 push 44,55
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 8'hDD, 8'h44}, // 14 strobe DD/44
        {1'b0, 1'b0, 16'h0000, 2'b10, 1'b0, 8'h00, 8'h00}, // 15 R7 flush (drops 55)
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 16 R10 take on empty
        {1'b1, 1'b0, 16'h00D8, 2'b00, 1'b0, 8'h00, 8'h00}, // 17 push D8,00
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 18 take D8 (pending)
        {1'b0, 1'b0, 16'h0000, 2'b10, 1'b0, 8'h00, 8'h00}, // 19 R7 flush drops pending
        {1'b1, 1'b0, 16'h99D8, 2'b00, 1'b0, 8'h00, 8'h00}, // 20 push D8,99
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 8'h00, 8'h00}, // 21 next-take, none pending
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b0, 8'h00, 8'h00}, // 22 take 99
        {1'b1, 1'b0, 16'hEEEE, 2'b10, 1'b0, 8'h00, 8'h00}, // 23 R7 fetch during flush lost
        {1'b1, 1'b0, 16'h12D9, 2'b00, 1'b0, 8'h00, 8'h00}, // 24 push D9,12
        {1'b0, 1'b0, 16'h0000, 2'b01, 1'b0, 8'h00, 8'h00}, // 25 take D9
        {1'b0, 1'b0, 16'h0000, 2'b11, 1'b1, 8'hD9, 8'h12}  // 26 strobe D9/12
    };

    // Drive one cycle of inputs at the falling edge, sample after the rising edge
    task automatic step(input logic f, input logic o, input logic [15:0] d, input logic [1:0] q);
        @(negedge clk);
        code_fetch = f;
        fetch_odd  = o;
        data_bus   = d;
        qstat      = q;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_esc(input string tag, input logic ev, input logic [7:0] eo,
                              input logic [7:0] em);
        n_chk++;
        if (esc_valid !== ev || (ev && (esc_opcode !== eo || esc_modrm !== em))) begin
            n_fail++;
            $display("FAIL %s: valid/op/modrm = %b/%h/%h, expected %b/%h/%h",
                     tag, esc_valid, esc_opcode, esc_modrm, ev, eo, em);
        end
    endtask

    task automatic expect_err(input string tag, input logic e);
        n_chk++;
        if (ovf_err !== e) begin
            n_fail++;
            $display("FAIL %s: ovf_err = %b, expected %b", tag, ovf_err, e);
        end
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n      = 1'b0;
        host_8bit  = sel;
        code_fetch = 1'b0;
        fetch_odd  = 1'b0;
        data_bus   = '0;
        qstat      = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        expect_esc("R1 reset strobe", 1'b0, 8'h00, 8'h00);
        expect_err("R1 reset error flag", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        // 16-bit host, vector table (R4 R5 R6 R7 R8 R9 R10)
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][36], VEC[i][35], VEC[i][34:19], VEC[i][18:17]);
            expect_esc($sformatf("R8 table row %0d", i), VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
            expect_err($sformatf("R3 table row %0d", i), 1'b0);
        end

        // R3: fill to depth 6, then one more fetch overflows without overwriting
        step(1'b1, 1'b0, 16'h01D9, 2'b00);
        step(1'b1, 1'b0, 16'h0302, 2'b00);
        step(1'b1, 1'b0, 16'h0504, 2'b00);
        expect_err("R3 exact fill", 1'b0);
        step(1'b1, 1'b0, 16'hDBDB, 2'b00);
        expect_err("R3 overflow flagged", 1'b1);
        step(1'b0, 1'b0, 16'h0000, 2'b01);
        step(1'b0, 1'b0, 16'h0000, 2'b11);
        expect_esc("R3 head intact after overflow", 1'b1, 8'hD9, 8'h01);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 16'h0000, 2'b01);
        step(1'b0, 1'b0, 16'h0000, 2'b01);
        step(1'b0, 1'b0, 16'h0000, 2'b11);
        expect_esc("R3 dropped fetch absent / R10 empty take", 1'b0, 8'h00, 8'h00);
        step(1'b0, 1'b0, 16'h0000, 2'b10);
        expect_err("R3 sticky across flush", 1'b1);

        // R1: reset clears the sticky flag (checked inside do_reset)
        // R2: 8-bit host, then width input flipped after reset
        do_reset(1'b1);
        host_8bit = 1'b0;
        step(1'b1, 1'b1, 16'h11DB, 2'b00);
        step(1'b1, 1'b0, 16'h2244, 2'b00);
        step(1'b0, 1'b0, 16'h0000, 2'b01);
        step(1'b0, 1'b0, 16'h0000, 2'b11);
        expect_esc("R2 R4 narrow low lane only", 1'b1, 8'hDB, 8'h44);
        step(1'b1, 1'b0, 16'h0001, 2'b00);
        step(1'b1, 1'b0, 16'h0002, 2'b00);
        step(1'b1, 1'b0, 16'h0003, 2'b00);
        step(1'b1, 1'b0, 16'h0004, 2'b00);
        expect_err("R2 narrow depth 4 fits", 1'b0);
        step(1'b1, 1'b0, 16'h0005, 2'b00);
        expect_err("R2 narrow fifth byte overflows", 1'b1);

        report();
    end

endmodule